// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and the calendar in packed BCD fields: seconds, minutes, hours, day of week, date, month and a two-digit year. A prescaler divides the 32.768 kHz reference clock by `DIV` and produces a one-cycle `tick`. Each tick advances the seconds, and a carry passes up through the fields as each one wraps. The date wraps according to the length of the current month, and February gets a 29th day in leap years.

The hours field holds its own format bit, which selects a 12-hour or a 24-hour count. The bit below it is the PM flag in 12-hour format and the tens digit for 20 to 23 in 24-hour format. A write port loads any one field. A combinational read port returns any field with its unused bits at zero. While the active-low `osc_en_n` input is high, the prescaler and all fields hold their values.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, addresses 0 to 6 read 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00. The hours value 0x00 means 24-hour format, hour zero.
- R2: While `osc_en_n` is 0, `tick` is high for exactly one clock cycle in every `DIV` cycles. Each tick advances the seconds by one in BCD.
- R3: While `osc_en_n` is 1, `tick` stays low and no field or prescaler count changes. When the input returns to 0, the count resumes from where it stopped.
- R4: A write to address 0 (seconds) clears the prescaler. The next seconds advance therefore happens exactly `DIV` cycles after the write edge.
- R5: Seconds (address 0, bits 6:0) and minutes (address 1, bits 6:0) count 00 to 59 in BCD. On wrapping to 00, each carries into the next field.
- R6: When hours bit 6 is 0 (24-hour format), bits 5:4 hold the tens digit 0 to 2 and bits 3:0 hold the units. The hour 23 wraps to 00 and advances day of week and date.
- R7: When hours bit 6 is 1 (12-hour format), bit 5 is PM (1 = PM) and bits 4:0 hold the BCD hour 01 to 12. The hours run 12, 01, 02 … 11. The step from 11 to 12 toggles PM, and only 11 PM to 12 AM advances day of week and date.
- R8: Day of week (address 3, bits 2:0) counts 1 to 7, and 7 wraps to 1 on a day carry.
- R9: Date (address 4, bits 5:0) wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and after the February length given by R10. Each wrap advances the month.
- R10: February has 29 days when the year (address 6) is a multiple of 4, with 00 counting as a multiple. It has 28 days in every other year.
- R11: Month (address 5, bits 4:0) wraps from 12 to 01 and advances the year. Year (address 6, bits 7:0) wraps from 99 to 00.
- R12: A write touches only the field it addresses and keeps only that field's bits: 7 for seconds, minutes and hours, 3 for day, 6 for date, 5 for month, 8 for year. Addresses 7 and above read 0. If a write lands in a tick cycle, the written field takes the written value and the other fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en_n | input | 1 | Active-low run control; 1 halts timekeeping |
| wr_en | input | 1 | Write strobe for one field |
| wr_addr | input | 3 | Field address of the write |
| wr_data | input | 8 | BCD value to write |
| rd_addr | input | 3 | Field address of the read |
| rd_data | output | 8 | Selected field, unused bits zero |
| tick | output | 1 | One-cycle pulse in the cycle before each seconds advance |

## Verification
A wrong prescaler count shows up on `tick` within one `DIV` period, as a missing or mistimed pulse, or as a seconds value that changes while the block is halted. A wrong carry or wrap rule stays hidden until a field reaches its limit. Left alone, that could take days or years. The bench therefore loads each boundary value directly and allows exactly one tick. This exposes any error in the whole carry chain, including month lengths, leap years and the 12-hour PM flip, in one `DIV` window.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;
  logic [6:0] sec_q, min_q, hour_q;
  logic [2:0] day_q;
  logic [5:0] date_q;
  logic [4:0] mon_q;
  logic [7:0] year_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  wire run = !osc_en_n;
  assign tick = run && (pre == PRE_LAST);

  wire w_sec  = wr_en && (wr_addr == 3'd0);
  wire w_min  = wr_en && (wr_addr == 3'd1);
  wire w_hour = wr_en && (wr_addr == 3'd2);
  wire w_day  = wr_en && (wr_addr == 3'd3);
  wire w_date = wr_en && (wr_addr == 3'd4);
  wire w_mon  = wr_en && (wr_addr == 3'd5);
  wire w_year = wr_en && (wr_addr == 3'd6);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      pre <= '0;
    else if (w_sec)  pre <= '0;
    else if (tick)   pre <= '0;
    else if (run)    pre <= pre + 1'b1;

  // seconds and minutes
  wire sec_wrap = (sec_q == 7'h59);
  wire min_wrap = (min_q == 7'h59);
  logic [7:0] sec_inc, min_inc;
  assign sec_inc = bcd_inc({1'b0, sec_q});
  assign min_inc = bcd_inc({1'b0, min_q});
  wire [6:0] sec_n = sec_wrap ? 7'h00 : sec_inc[6:0];
  wire [6:0] min_n = min_wrap ? 7'h00 : min_inc[6:0];

  // hours
  logic [6:0] hour_n;
  logic       hour_carry;
  logic [7:0] h12_inc, h24_inc;
  assign h12_inc = bcd_inc({3'b0, hour_q[4:0]});
  assign h24_inc = bcd_inc({2'b0, hour_q[5:0]});
  always_comb begin
    hour_carry = 1'b0;
    if (hour_q[6]) begin
      if (hour_q[4:0] == 5'h12)
        hour_n = {1'b1, hour_q[5], 5'h01};
      else if (hour_q[4:0] == 5'h11) begin
        hour_n     = {1'b1, ~hour_q[5], 5'h12};
        hour_carry = hour_q[5];
      end else
        hour_n = {1'b1, hour_q[5], h12_inc[4:0]};
    end else begin
      if (hour_q[5:0] == 6'h23) begin
        hour_n     = 7'h00;
        hour_carry = 1'b1;
      end else
        hour_n = {1'b0, h24_inc[5:0]};
    end
  end

  // calendar
  wire [2:0] day_n = (day_q == 3'd7) ? 3'd1 : day_q + 3'd1;

  logic [6:0] year_bin;
  assign year_bin = 7'(year_q[7:4]) * 7'd10 + 7'(year_q[3:0]);
  wire leap = (year_bin[1:0] == 2'b00);

  logic [5:0] last_date;
  always_comb
    case (mon_q)
      5'h02:                      last_date = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
      default:                    last_date = 6'h31;
    endcase

  wire date_wrap = (date_q == last_date);
  wire mon_wrap  = (mon_q == 5'h12);
  wire year_wrap = (year_q == 8'h99);
  logic [7:0] date_inc, mon_inc, year_inc;
  assign date_inc = bcd_inc({2'b0, date_q});
  assign mon_inc  = bcd_inc({3'b0, mon_q});
  assign year_inc = bcd_inc(year_q);
  wire [5:0] date_n = date_wrap ? 6'h01 : date_inc[5:0];
  wire [4:0] mon_n  = mon_wrap  ? 5'h01 : mon_inc[4:0];
  wire [7:0] year_n = year_wrap ? 8'h00 : year_inc;

  wire adv_min  = tick && sec_wrap;
  wire adv_hour = adv_min && min_wrap;
  wire adv_day  = adv_hour && hour_carry;
  wire adv_mon  = adv_day && date_wrap;
  wire adv_year = adv_mon && mon_wrap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sec_q  <= 7'h00;
      min_q  <= 7'h00;
      hour_q <= 7'h00;
      day_q  <= 3'd1;
      date_q <= 6'h01;
      mon_q  <= 5'h01;
      year_q <= 8'h00;
    end else begin
      if (w_sec)         sec_q  <= wr_data[6:0];
      else if (tick)     sec_q  <= sec_n;
      if (w_min)         min_q  <= wr_data[6:0];
      else if (adv_min)  min_q  <= min_n;
      if (w_hour)        hour_q <= wr_data[6:0];
      else if (adv_hour) hour_q <= hour_n;
      if (w_day)         day_q  <= wr_data[2:0];
      else if (adv_day)  day_q  <= day_n;
      if (w_date)        date_q <= wr_data[5:0];
      else if (adv_day)  date_q <= date_n;
      if (w_mon)         mon_q  <= wr_data[4:0];
      else if (adv_mon)  mon_q  <= mon_n;
      if (w_year)        year_q <= wr_data;
      else if (adv_year) year_q <= year_n;
    end

  always_comb
    case (rd_addr)
      3'd0:    rd_data = {1'b0, sec_q};
      3'd1:    rd_data = {1'b0, min_q};
      3'd2:    rd_data = {1'b0, hour_q};
      3'd3:    rd_data = {5'b0, day_q};
      3'd4:    rd_data = {2'b0, date_q};
      3'd5:    rd_data = {3'b0, mon_q};
      3'd6:    rd_data = year_q;
      default: rd_data = 8'h00;
    endcase
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk #(
  parameter int PW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          osc_en_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic          tick,
  input logic [PW-1:0] pre,
  input logic [6:0]    sec,
  input logic [6:0]    min,
  input logic [6:0]    hour,
  input logic [2:0]    day
);
  // R3
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en_n && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(day) && $stable(pre)));

  // R3
  halt_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en_n |-> !tick);

  // R4
  sec_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (pre == '0));

  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(sec));

  // R5
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sec == 7'h59 && !wr_en) |=> (sec == 7'h00));

  // R8
  day_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(day) || (day == (($past(day) == 3'd7) ? 3'd1 : 3'($past(day) + 3'd1)))));
endmodule

bind bcd_rtc bcd_rtc_chk #(.PW(PW)) u_bcd_rtc_chk (
  .clk(clk), .rst_n(rst_n), .osc_en_n(osc_en_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .tick(tick), .pre(pre), .sec(sec_q), .min(min_q), .hour(hour_q), .day(day_q)
);

// File: tb/test_bcd_rtc.sv
`timescale 1ns/1ps
module test_bcd_rtc;
  localparam int DIV = 4;
  localparam int NV  = 18;
  // {sec,min,hour,day,date,month,year} before one tick, then expected after it
  localparam logic [111:0] VEC [NV] = '{
    112'h00000001010100_01000001010100,
    112'h59592307311299_00000001010100,
    112'h59591902100507_00002002100507,
    112'h59595102100507_00007202100507,
    112'h59597103150607_00005204160607,
    112'h59597203150607_00006103150607,
    112'h59592305280223_00000006010323,
    112'h59592305280224_00000006290224,
    112'h59592306290224_00000007010324,
    112'h59592301300450_00000002010550,
    112'h59592301300150_00000002310150,
    112'h59592301280200_00000002290200,
    112'h59594901050505_00005001050505,
    112'h59592301280219_00000002010319,
    112'h09591201010100_10591201010100,
    112'h59091201010100_00101201010100,
    112'h59592304300901_00000005011001,
    112'h59592304301101_00000005011201
  };

  logic clk = 0, rst_n = 0, osc_en_n = 0, wr_en = 0, tick;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcd_rtc #(.DIV(DIV)) i_bcd_rtc (
    .clk(clk), .rst_n(rst_n), .osc_en_n(osc_en_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick)
  );

  function automatic string vtag(input int i, input int f);
    if (f == 3) return "R8";
    case (i)
      0: return "R2";
      1: return "R11";
      2: return "R6";
      3, 4, 5, 12: return "R7";
      6, 7, 8, 11, 13: return "R10";
      9, 10, 16, 17: return "R9";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_tick();
    for (int k = 0; k < 4 * DIV; k++) begin
      @(negedge clk);
      if (tick) break;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);

    // R1 reset values
    for (int f = 0; f < 7; f++) begin
      rd(3'(f), d);
      chk("R1", d, (f >= 3 && f <= 5) ? 8'h01 : 8'h00);
    end
    rst_n = 1;

    // R2 tick period
    begin
      int t1 = -1, t2 = -1;
      for (int k = 0; k < 3 * DIV; k++) begin
        @(negedge clk);
        if (tick) begin
          if (t1 < 0) t1 = k;
          else if (t2 < 0) t2 = k;
        end
      end
      chk("R2", t2 - t1, DIV);
    end

    // R3 halt and resume
    osc_en_n = 1;
    wr(3'd0, 8'h30);
    osc_en_n = 0;
    wait_tick();
    osc_en_n = 1;
    begin
      int seen = 0;
      for (int k = 0; k < 3 * DIV; k++) begin
        @(negedge clk);
        if (tick) seen++;
      end
      chk("R3", seen, 0);
    end
    rd(3'd0, d); chk("R3", d, 8'h30);
    osc_en_n = 0;
    #1 chk("R3", tick, 1);
    @(negedge clk);
    rd(3'd0, d); chk("R3", d, 8'h31);

    // R4 seconds write restarts the prescaler
    @(negedge clk);
    wr(3'd0, 8'h20);
    for (int k = 1; k < DIV; k++) begin
      @(negedge clk);
      rd(3'd0, d); chk("R4", d, 8'h20);
    end
    @(negedge clk);
    rd(3'd0, d); chk("R4", d, 8'h21);

    // vector table: load, one tick, compare
    for (int v = 0; v < NV; v++) begin
      osc_en_n = 1;
      for (int f = 0; f < 7; f++) wr(3'(f), VEC[v][111 - 8 * f -: 8]);
      osc_en_n = 0;
      repeat (DIV) @(negedge clk);
      osc_en_n = 1;
      for (int f = 0; f < 7; f++) begin
        rd(3'(f), d);
        chk(vtag(v, f), d, VEC[v][55 - 8 * f -: 8]);
      end
    end

    // R12 field widths, isolation, unused address
    osc_en_n = 1;
    wr(3'd0, 8'h15);
    wr(3'd3, 8'hFF); rd(3'd3, d); chk("R12", d, 8'h07);
    wr(3'd4, 8'hFF); rd(3'd4, d); chk("R12", d, 8'h3F);
    wr(3'd5, 8'hFF); rd(3'd5, d); chk("R12", d, 8'h1F);
    wr(3'd1, 8'h42); rd(3'd0, d); chk("R12", d, 8'h15);
    rd(3'd7, d); chk("R12", d, 8'h00);

    // R12 write in a tick cycle
    wr(3'd0, 8'h59);
    wr(3'd1, 8'h10);
    osc_en_n = 0;
    wait_tick();
    wr_en = 1; wr_addr = 3'd1; wr_data = 8'h30;
    @(negedge clk);
    wr_en = 0; osc_en_n = 1;
    rd(3'd0, d); chk("R12", d, 8'h00);
    rd(3'd1, d); chk("R12", d, 8'h30);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule